// File: doc/BRIEF.md
# Pipelined Round-Robin Bus Arbiter

This block lets several bus masters share one system bus. Every master raises its own request line. A single central arbiter holds bus ownership with exactly one master at any time and shows which master that is on a one-hot grant vector. The master that owns the bus drives the shared address phase, which carries an address, a write flag and a transfer type. When the slave accepts that address phase, the transfer moves into a registered data phase. In the same cycle a new address phase starts for the next owner, so the address of one transfer overlaps the data of the previous one.

A single slave-ready input paces both stages. While it is low, the data phase is extended and nothing moves: the pending address phase, the data-phase registers and the grant all keep their values. Ownership rotates round-robin on every accepted cycle. The search for the next owner starts just after the present owner, and the present owner has the lowest priority. When no master is requesting, the bus stays parked on its last owner and drives an idle transfer type.

Top module: `bus_share_arb`

## Requirements
- R1: During and right after reset, the grant is one-hot on master 0, the bus transfer type is idle (0) and no master ready output is high.
- R2: gnt_o is one-hot in every cycle. Bit i marks master i as the owner.
- R3: On a clock edge with slv_ready_i high and at least one request, ownership passes to the first requesting master found in ascending cyclic index order starting at owner+1. The present owner keeps the bus only when it is the sole requester.
- R4: On a clock edge with no request, ownership does not change, and bus_trans_o reads 0 (idle) while the owner is not requesting.
- R5: bus_addr_o and bus_write_o equal the owner's addr_i slot (bits i*AW and up) and write_i bit. bus_trans_o is 1 exactly when the owner's request is high.
- R6: An active address phase accepted at an edge with slv_ready_i high becomes the data phase of that same master from the next cycle on. bus_wdata_o then carries that master's wdata_i slot (bits i*DW and up), and mst_rdata_o always carries slv_rdata_i.
- R7: An edge with slv_ready_i low changes neither the grant nor the data-phase owner. While slv_ready_i is low, every mst_ready_o bit is 0.
- R8: mst_ready_o bit i is 1 only when the data phase is active, belongs to master i and slv_ready_i is high. At most one bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | N_MST | Bus request, one bit per master |
| addr_i | input | N_MST*AW | Packed per-master addresses |
| write_i | input | N_MST | Per-master write flag |
| wdata_i | input | N_MST*DW | Packed per-master write data |
| gnt_o | output | N_MST | One-hot bus ownership |
| bus_addr_o | output | AW | Address-phase address |
| bus_write_o | output | 1 | Address-phase write flag |
| bus_trans_o | output | 1 | Address-phase transfer type, 1 active, 0 idle |
| bus_wdata_o | output | DW | Data-phase write data |
| slv_ready_i | input | 1 | Slave ready; low extends the data phase |
| slv_rdata_i | input | DW | Slave read data |
| mst_ready_o | output | N_MST | Per-master data-phase completion |
| mst_rdata_o | output | DW | Read data returned to masters |

## Verification
The bench builds the block with its default parameters: four masters and 16-bit address and data. With four masters there are only sixteen request patterns, so the bench can steer ownership to every master in turn and apply each of the sixteen patterns from each owner. It does this once with the slave ready and once with the slave stalling. This covers every rotation, the wrap from the last master back to master 0, parking with no requests, the sole-requester hold and the stall freeze. A cycle-level model built from the requirements predicts the grant, the address phase and the data phase in every cycle.

// File: rtl/bsa_pkg.sv
package bsa_pkg;
  typedef enum logic {
    TR_IDLE = 1'b0,
    TR_XFER = 1'b1
  } tr_e;
endpackage

// File: rtl/bsa_rr_sel.sv
module bsa_rr_sel #(
  parameter int N_MST = 4,
  localparam int IW = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input  logic [N_MST-1:0] req_i,
  input  logic [IW-1:0]    last_i,
  output logic [IW-1:0]    pick_o,
  output logic             any_o
);
  // Scan from farthest to nearest so the nearest requester after last wins.
  always_comb begin
    pick_o = last_i;
    any_o  = 1'b0;
    for (int k = N_MST; k >= 1; k--) begin
      int idx;
      idx = (int'(last_i) + k) % N_MST;
      if (req_i[idx]) begin
        pick_o = IW'(idx);
        any_o  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/bsa_owner_reg.sv
module bsa_owner_reg #(
  parameter int N_MST = 4,
  localparam int IW = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  input  logic          any_i,
  input  logic [IW-1:0] pick_i,
  output logic [IW-1:0] own_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             own_o <= '0;
    else if (adv_i && any_i) own_o <= pick_i;
  end
endmodule

// File: rtl/bsa_dphase.sv
module bsa_dphase #(
  parameter int N_MST = 4,
  localparam int IW = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  input  logic          ap_act_i,
  input  logic [IW-1:0] ap_own_i,
  output logic          dp_act_o,
  output logic [IW-1:0] dp_own_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dp_act_o <= 1'b0;
      dp_own_o <= '0;
    end else if (adv_i) begin
      dp_act_o <= ap_act_i;
      dp_own_o <= ap_own_i;
    end
  end
endmodule

// File: rtl/bus_share_arb.sv
module bus_share_arb #(
  parameter int N_MST = 4,
  parameter int AW    = 16,
  parameter int DW    = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_MST-1:0]   req_i,
  input  logic [N_MST*AW-1:0] addr_i,
  input  logic [N_MST-1:0]   write_i,
  input  logic [N_MST*DW-1:0] wdata_i,
  output logic [N_MST-1:0]   gnt_o,
  output logic [AW-1:0]      bus_addr_o,
  output logic               bus_write_o,
  output logic               bus_trans_o,
  output logic [DW-1:0]      bus_wdata_o,
  input  logic               slv_ready_i,
  input  logic [DW-1:0]      slv_rdata_i,
  output logic [N_MST-1:0]   mst_ready_o,
  output logic [DW-1:0]      mst_rdata_o
);
  import bsa_pkg::*;
  localparam int IW = (N_MST > 1) ? $clog2(N_MST) : 1;

  logic [IW-1:0] own, pick, dp_own;
  logic          any_req, dp_act;
  tr_e           ap_tr;
  logic [AW-1:0] addr_a  [N_MST];
  logic [DW-1:0] wdata_a [N_MST];

  bsa_rr_sel #(.N_MST(N_MST)) u_sel (
    .req_i (req_i), .last_i(own), .pick_o(pick), .any_o(any_req)
  );

  bsa_owner_reg #(.N_MST(N_MST)) u_own (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(slv_ready_i),
    .any_i(any_req), .pick_i(pick), .own_o(own)
  );

  assign ap_tr = req_i[own] ? TR_XFER : TR_IDLE;

  bsa_dphase #(.N_MST(N_MST)) u_dp (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(slv_ready_i),
    .ap_act_i(ap_tr == TR_XFER), .ap_own_i(own),
    .dp_act_o(dp_act), .dp_own_o(dp_own)
  );

  for (genvar g = 0; g < N_MST; g++) begin : g_mst
    assign addr_a[g]      = addr_i[g*AW +: AW];
    assign wdata_a[g]     = wdata_i[g*DW +: DW];
    assign gnt_o[g]       = (own == IW'(g));
    assign mst_ready_o[g] = dp_act && slv_ready_i && (dp_own == IW'(g));
  end

  assign bus_addr_o  = addr_a[own];
  assign bus_write_o = write_i[own];
  assign bus_trans_o = (ap_tr == TR_XFER);
  assign bus_wdata_o = wdata_a[dp_own];
  assign mst_rdata_o = slv_rdata_i;
endmodule

// File: rtl/bus_share_arb_chk.sv
module bus_share_arb_chk #(
  parameter int N_MST = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_MST-1:0] req_i,
  input logic [N_MST-1:0] gnt_o,
  input logic             bus_trans_o,
  input logic             slv_ready_i,
  input logic [N_MST-1:0] mst_ready_o
);
  AST_GNT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(gnt_o)); // R2

  AST_SOLE_REQ_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slv_ready_i && $onehot(req_i)) |=> (gnt_o == $past(req_i))); // R3

  AST_PARK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slv_ready_i && req_i == '0) |=> $stable(gnt_o)); // R4

  AST_DATA_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slv_ready_i && bus_trans_o) |=> (!slv_ready_i || mst_ready_o == $past(gnt_o))); // R6

  AST_STALL_GNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slv_ready_i |=> $stable(gnt_o)); // R7

  AST_STALL_NO_RDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slv_ready_i |-> (mst_ready_o == '0)); // R7

  AST_RDY_ONEHOT0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(mst_ready_o)); // R8
endmodule

bind bus_share_arb bus_share_arb_chk #(.N_MST(N_MST)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .gnt_o(gnt_o),
  .bus_trans_o(bus_trans_o), .slv_ready_i(slv_ready_i), .mst_ready_o(mst_ready_o)
);

// File: tb/sim_bus_share_arb.sv
module sim_bus_share_arb;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int AW = 16;
  localparam int DW = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    req = '0;
  logic [N*AW-1:0] addr = '0;
  logic [N-1:0]    wr = '0;
  logic [N*DW-1:0] wdata = '0;
  logic            rdy = 1'b1;
  logic [DW-1:0]   rdata = '0;
  logic [N-1:0]    gnt, mrdy;
  logic [AW-1:0]   baddr;
  logic            bwr, btr;
  logic [DW-1:0]   bwdata, mrdata;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  // reference state from the requirements
  int m_own = 0;
  bit m_dpv = 0;
  int m_dpo = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_share_arb #(.N_MST(N), .AW(AW), .DW(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr), .write_i(wr),
    .wdata_i(wdata), .gnt_o(gnt), .bus_addr_o(baddr), .bus_write_o(bwr),
    .bus_trans_o(btr), .bus_wdata_o(bwdata), .slv_ready_i(rdy),
    .slv_rdata_i(rdata), .mst_ready_o(mrdy), .mst_rdata_o(mrdata)
  );

  function automatic int next_owner(logic [N-1:0] r, int cur);
    for (int k = 1; k <= N; k++) begin
      if (r[(cur + k) % N]) return (cur + k) % N;
    end
    return cur;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_own <= 0; m_dpv <= 0; m_dpo <= 0;
    end else if (rdy) begin
      m_dpv <= req[m_own];
      m_dpo <= m_own;
      m_own <= next_owner(req, m_own);
    end
  end

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h (cycle %0d)", tag, got, exp, cyc);
    end
  endtask

  task automatic check_all(string gtag);
    logic [N-1:0] exp_rdy;
    exp_rdy = (m_dpv && rdy) ? N'(1 << m_dpo) : '0;
    check(gtag, 32'(gnt), 32'(1 << m_own));
    check(req[m_own] ? "R5 trans" : "R4 idle trans", 32'(btr), 32'(req[m_own]));
    check("R5 addr", 32'(baddr), 32'(addr[m_own*AW +: AW]));
    check("R5 write", 32'(bwr), 32'(wr[m_own]));
    check("R6 wdata", 32'(bwdata), 32'(wdata[m_dpo*DW +: DW]));
    check("R6 rdata", 32'(mrdata), 32'(rdata));
    check(rdy ? "R8 ready" : "R7 ready", 32'(mrdy), 32'(exp_rdy));
  endtask

  // drive one cycle at the falling edge, check before the rising edge
  task automatic step(logic [N-1:0] r, logic s, string gtag);
    @(negedge clk);
    cyc++;
    req = r;
    rdy = s;
    for (int i = 0; i < N; i++) begin
      addr[i*AW +: AW]  = AW'(16'h1000 * (i + 1) + cyc);
      wdata[i*DW +: DW] = DW'(16'hA000 ^ (i << 8) ^ cyc);
      wr[i]             = ((cyc + i) % 2) == 1;
    end
    rdata = DW'(16'h5A00 + cyc);
    #(CLK_PERIOD/4);
    check_all(gtag);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    #(CLK_PERIOD/4);
    // R1 reset state
    check("R1 gnt", 32'(gnt), 32'h1);
    check("R1 trans", 32'(btr), 32'h0);
    check("R1 ready", 32'(mrdy), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    step('0, 1'b1, "R1 gnt after reset");
    step('0, 1'b1, "R4 parked gnt");
    // sweep: every owner x every pattern x ready high/low
    for (int o = 0; o < N; o++) begin
      for (int p = 0; p < (1 << N); p++) begin
        for (int s = 1; s >= 0; s--) begin
          step(N'(1 << o), 1'b1, "R3 steer gnt");
          step(N'(p), s[0], s[0] ? "R3 rotate gnt" : "R7 stall gnt");
          step(N'(p), 1'b1, p == 0 ? "R4 park gnt" : "R3 rotate gnt");
          step('0, 1'b1, "R6 drain gnt");
        end
      end
    end
    // longer stall runs with all masters requesting
    for (int t = 0; t < 40; t++) begin
      step('1, (t % 3) != 0, (t % 3) != 0 ? "R3 all-req gnt" : "R7 stall gnt");
    end
    done = 1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog (all requirements) got=hung exp=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule